// File: doc/BRIEF.md
# Clock Loss Detector with Failover

This block watches a primary clock and decides when it has gone quiet. The backup clock runs the detector, and every timeout is counted in backup periods. The primary clock drives a single toggle flop. That flop's output crosses into the backup domain through a synchronizer. Any change seen there counts as one sign of life and restarts a silence counter.

When the silence lasts as long as the selected limit, a loss flag rises. The mux select output then moves to the backup clock. The limit is either short or long, picked by a plain select input.

Recovery is not symmetric with failure. The first sign of life after a loss drops the flag at once, and the select returns to the primary. No restart timeout applies. The only extra delay is the synchronizer latency.

The timeout select should be tied high when nothing drives it, so that the long limit applies. The analog smoothing of the switched clock is left to the surrounding logic.

Top module: `clk_loss_failover`

## Requirements
- R1: While `rst` is high, `loss` and `use_bkp` are 0 at once (asynchronous). After `rst` falls, the silence count starts from zero.
- R2: With `long_sel` = 0 and the primary running at the backup frequency, `loss` rises between 2 and 4 backup rising edges (inclusive) after the last primary rising edge.
- R3: With `long_sel` = 1, `loss` rises between 32 and 64 backup rising edges (inclusive) after the last primary rising edge.
- R4: `use_bkp` equals `loss`. A value of 1 selects the backup clock and 0 selects the primary clock.
- R5: After a loss, `loss` and `use_bkp` fall within 3 backup rising edges of the first primary rising edge. No restart timeout applies.
- R6: `loss` stays 0 while the primary clock keeps running. In long mode, primary periods of 6 to 41 ns are covered. In short mode, the primary period equals the backup period.
- R7: While the primary stays silent, `loss` stays 1 for any length of time. The silence counter saturates at its terminal count and never wraps.
- R8: A change of `long_sel` by itself neither raises nor clears `loss`. While the primary is silent, the new limit applies from the next backup rising edge: going from long to short after a silence longer than the short limit raises `loss` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prim_clk | input | 1 | Primary clock being monitored |
| bkp_clk | input | 1 | Backup clock; clocks the timeout logic |
| rst | input | 1 | Active-high asynchronous reset |
| long_sel | input | 1 | Timeout select: 0 short, 1 long |
| loss | output | 1 | High when the primary clock is judged lost |
| use_bkp | output | 1 | Mux select: 1 backup clock, 0 primary clock |

## Verification
The bench stops the primary clock at random phases, in both modes. It counts backup edges from the last primary edge to the rise of the flag.

A design that counted in the wrong domain, or left out the synchronizer compensation, would land outside the 2..4 or 32..64 windows. The bench then restarts the primary and times the flag's fall. A design that ran a restart timeout would take far more than 3 edges.

The bench flips the timeout select in three situations: while the primary runs, while the flag is set, and during a silence. A design that let the select act on the flag directly would raise it falsely, clear it, or miss the long-to-short rise. A long hold after failure checks that a wrapping counter never lets the flag lapse.

// File: rtl/clf_pkg.sv
package clf_pkg;
  // Timeout select encoding on the long_sel pin
  typedef enum logic {
    TO_SHORT = 1'b0,
    TO_LONG  = 1'b1
  } to_mode_e;

  // Counter limit that places the flag rise nominal_periods after the
  // last primary edge, given sync_stages flops plus one history flop
  function automatic int limit_for(input int nominal_periods, input int sync_stages);
    int v;
    v = nominal_periods - sync_stages - 1;
    return (v < 0) ? 0 : v;
  endfunction
endpackage

// File: rtl/clf_prim_toggle.sv
module clf_prim_toggle (
  input  logic prim_clk,
  input  logic rst,
  output logic tgl
);
  // Flips on every primary rising edge; its level carries activity
  always_ff @(posedge prim_clk or posedge rst) begin
    if (rst) tgl <= 1'b0;
    else     tgl <= ~tgl;
  end
endmodule

// File: rtl/clf_sync_detect.sv
module clf_sync_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic act
);
  logic [STAGES-1:0] chain;
  logic              hist;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) hist <= 1'b0;
    else     hist <= chain[STAGES-1];
  end

  // One detected primary transition per change of the synchronized level
  assign act = chain[STAGES-1] ^ hist;
endmodule

// File: rtl/clf_timeout.sv
module clf_timeout #(
  parameter int LIM_SHORT = 0,
  parameter int LIM_LONG  = 45,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic long_sel,
  output logic loss
);
  import clf_pkg::*;

  localparam logic [CNT_W-1:0] SAT   = CNT_W'(LIM_LONG > LIM_SHORT ? LIM_LONG : LIM_SHORT);
  localparam logic [CNT_W-1:0] L_SH  = CNT_W'(LIM_SHORT);
  localparam logic [CNT_W-1:0] L_LG  = CNT_W'(LIM_LONG);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim = (to_mode_e'(long_sel) == TO_LONG) ? L_LG : L_SH;

  // Silence counter: cleared by activity, saturating at SAT
  always_ff @(posedge clk or posedge rst) begin
    if (rst)             cnt <= '0;
    else if (act)        cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end

  // Flag: set when silence reaches the current limit, cleared only by activity
  always_ff @(posedge clk or posedge rst) begin
    if (rst)              loss <= 1'b0;
    else if (act)         loss <= 1'b0;
    else if (cnt >= lim)  loss <= 1'b1;
  end

  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt == SAT && !act) |=> (cnt == SAT));

  assert_act_clears_R5: assert property (@(posedge clk) disable iff (rst)
    act |=> (cnt == '0 && !loss));

  assert_loss_held_R7: assert property (@(posedge clk) disable iff (rst)
    (loss && !act) |=> loss);

  // R2 and R3: a rise is only allowed once the silence reached the limit
  assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(loss) |-> ($past(cnt) >= $past(lim)));

  assert_no_early_R6: assert property (@(posedge clk) disable iff (rst)
    (!loss && (cnt < lim)) |=> !loss);
endmodule

// File: rtl/clk_loss_failover.sv
module clk_loss_failover #(
  parameter int SHORT_TO    = 3,
  parameter int LONG_TO     = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic prim_clk,
  input  logic bkp_clk,
  input  logic rst,
  input  logic long_sel,
  output logic loss,
  output logic use_bkp
);
  import clf_pkg::*;

  localparam int LIM_SHORT = limit_for(SHORT_TO, SYNC_STAGES);
  localparam int LIM_LONG  = limit_for(LONG_TO, SYNC_STAGES);
  localparam int LIM_MAX   = (LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT;
  localparam int CNT_W     = (LIM_MAX < 1) ? 1 : $clog2(LIM_MAX + 1);

  logic tgl;
  logic act;

  clf_prim_toggle u_tgl (
    .prim_clk (prim_clk),
    .rst      (rst),
    .tgl      (tgl)
  );

  clf_sync_detect #(.STAGES(SYNC_STAGES)) u_det (
    .clk (bkp_clk),
    .rst (rst),
    .din (tgl),
    .act (act)
  );

  clf_timeout #(
    .LIM_SHORT (LIM_SHORT),
    .LIM_LONG  (LIM_LONG),
    .CNT_W     (CNT_W)
  ) u_to (
    .clk      (bkp_clk),
    .rst      (rst),
    .act      (act),
    .long_sel (long_sel),
    .loss     (loss)
  );

  // Mux select follows the flag: 1 picks the backup clock
  assign use_bkp = loss;
endmodule

// File: tb/clk_loss_failover_test.sv
`timescale 1ns/1ps
module clk_loss_failover_test;
  logic prim_clk = 1'b0;
  logic bkp_clk  = 1'b0;
  logic rst      = 1'b1;
  logic long_sel = 1'b1;
  logic loss, use_bkp;

  int n_checks = 0;
  int n_fail   = 0;

  clk_loss_failover uut (
    .prim_clk (prim_clk),
    .bkp_clk  (bkp_clk),
    .rst      (rst),
    .long_sel (long_sel),
    .loss     (loss),
    .use_bkp  (use_bkp)
  );

  always #2.5 bkp_clk = ~bkp_clk;   // 200 MHz

  int bk_n = 0;
  always @(posedge bkp_clk) bk_n <= bk_n + 1;

  int last_pe_bk = 0;
  int first_pe_bk = 0;
  always @(posedge prim_clk) last_pe_bk = bk_n;

  logic loss_q = 1'b0;
  int   rise_bk = -1;
  int   fall_bk = -1;
  bit   watch = 1'b0;
  int   false_hits = 0;
  always @(negedge bkp_clk) begin
    if (loss && !loss_q)  rise_bk = bk_n;
    if (!loss && loss_q)  fall_bk = bk_n;
    if (watch && loss)    false_hits++;
    loss_q = loss;
  end

  function automatic int win_lo(bit lng); return lng ? 32 : 2; endfunction
  function automatic int win_hi(bit lng); return lng ? 64 : 4; endfunction
  function automatic int rec_max(); return 3; endfunction

  task automatic check(bit ok, string req, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic run_prim(int cycles, real half, bit flip);
    real phase;
    int  warm;
    phase = 0.7 + real'($urandom % 37) * 0.1;
    warm  = int'(25.0 / (2.0 * half)) + 1;
    @(posedge bkp_clk);
    #(phase);
    for (int i = 0; i < cycles; i++) begin
      prim_clk = 1'b1;
      if (i == 0) first_pe_bk = bk_n;
      if (i == warm) watch = 1'b1;
      if (flip && i == cycles / 2) long_sel = ~long_sel;
      #(half);
      prim_clk = 1'b0;
      #(half);
    end
    watch = 1'b0;
  endtask

  task automatic await_rise(int limit);
    for (int k = 0; k < limit && rise_bk < 0; k++) @(negedge bkp_clk);
    @(negedge bkp_clk);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit   was_loss, lng, md, flip;
    real  half;
    int   d;
    void'($urandom(32'h1f2e3d4c));

    // R1: reset state
    #12.3;
    check(loss == 1'b0, "R1 loss in reset", loss, 0);
    check(use_bkp == 1'b0, "R1 use_bkp in reset", use_bkp, 0);
    @(negedge bkp_clk); rst = 1'b0;
    repeat (10) @(negedge bkp_clk);
    check(loss == 1'b0, "R1 count starts at zero after reset", loss, 0);

    // R8: select change during silence
    long_sel = 1'b1;
    run_prim(30, 2.5, 1'b0);
    rise_bk = -1;
    repeat (10) @(negedge bkp_clk);
    check(loss == 1'b0, "R3 no early rise in long mode", loss, 0);
    long_sel = 1'b0;
    @(negedge bkp_clk);
    check(loss == 1'b1, "R8 long to short applies at next edge", loss, 1);
    long_sel = 1'b1;
    repeat (5) @(negedge bkp_clk);
    check(loss == 1'b1, "R8 short to long keeps flag", loss, 1);
    check(use_bkp == 1'b1, "R4 select follows flag", use_bkp, 1);

    // R1: reset while lost
    #1.0 rst = 1'b1;
    #0.5;
    check(loss == 1'b0, "R1 async clear of flag", loss, 0);
    check(use_bkp == 1'b0, "R1 async clear of select", use_bkp, 0);
    @(negedge bkp_clk); rst = 1'b0;

    // Random scenarios
    for (int it = 0; it < 24; it++) begin
      lng = 1'($urandom % 2);
      long_sel = lng;
      if (lng && ($urandom % 3 != 0)) half = real'(3 + $urandom % 18) + 0.3;
      else half = 2.5;
      flip = (half == 2.5) && ($urandom % 2 == 1);
      @(negedge bkp_clk);
      was_loss = loss;
      fall_bk = -1;
      false_hits = 0;
      run_prim(30 + $urandom % 40, half, flip);
      if (was_loss) begin
        d = fall_bk - first_pe_bk;
        check(fall_bk >= 0 && d >= 1 && d <= rec_max(), "R5 recovery delay", d, rec_max());
      end
      check(false_hits == 0, "R6 no loss while primary runs", false_hits, 0);
      check(use_bkp == 1'b0, "R4 primary selected while running", use_bkp, 0);
      md = long_sel;
      rise_bk = -1;
      await_rise(90);
      d = rise_bk - last_pe_bk;
      if (md) check(rise_bk >= 0 && d >= win_lo(1) && d <= win_hi(1), "R3 long timeout", d, 48);
      else    check(rise_bk >= 0 && d >= win_lo(0) && d <= win_hi(0), "R2 short timeout", d, 3);
      check(use_bkp == 1'b1, "R4 backup selected after loss", use_bkp, 1);
      repeat ($urandom % 100) @(negedge bkp_clk);
      check(loss == 1'b1, "R7 flag held during silence", loss, 1);
    end

    // R7: long silence, then R5 recovery
    long_sel = 1'b1;
    repeat (300) @(negedge bkp_clk);
    check(loss == 1'b1, "R7 no wrap after long silence", loss, 1);
    fall_bk = -1;
    run_prim(20, 2.5, 1'b0);
    d = fall_bk - first_pe_bk;
    check(fall_bk >= 0 && d <= rec_max(), "R5 recovery after saturation", d, rec_max());

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule